// File: doc/BRIEF.md
# DRAM Timing Sweep Test Sequencer

This block drives an abstract DRAM command bus to find how far the row activation delay or the precharge delay can be shortened before stored data comes back wrong. One run sweeps a single delay downward, one controller clock (2.5 ns) per step. The sweep starts at the standard delay and stops at a programmable floor. At every step the sequencer first rewrites the target row with a selectable data pattern under standard timing. It then runs the test sequence with the shortened delay, reads the affected cache lines back and counts the bits that differ from the pattern.

Two tests are available. The activation test opens the target row and reads line 0 exactly the reduced number of cycles later, because only that first read can be damaged. It then reads line 1 with full timing as a control. The precharge test opens and closes a second row, opens the target row the reduced number of cycles after that close, and reads several lines of the target row. A row has 128 cache lines of 64 bytes. Each read returns one line as a DW-bit word, and a memory model on the far side answers the reads.

Top module: `dram_sweep_seq`

## Requirements
- R1: After reset the block is idle: busy, done, line_valid and res_valid are 0 and cmd_op is NOP. Command codes are NOP=0, ACT=1, RD=2, WR=3, PRE=4.
- R2: Every step begins by opening the target row, writing the latched pattern into each line that the step will read, and closing the row, all with standard spacing.
- R3: In the activation test (test_pre=0), the RD of line 0 is issued exactly d cycles after the ACT of the target row, where d is the step's delay. The control RD of line 1 follows it only after at least the standard delay.
- R4: In the precharge test (test_pre=1), the block opens alt_row and then precharges. It issues the ACT of the target row exactly d cycles after that PRE and reads lines 0 to NPRE-1 in order.
- R5: The first step uses the standard delay (STD_DLY=6 cycles). Each later step uses one cycle less, down to the effective floor, and each step ends with a single res_valid pulse that carries its delay on res_dly.
- R6: A floor of 0 is treated as 1, and a floor above the standard delay is treated as the standard delay, which gives a single step.
- R7: Each read gives one line_valid pulse with line_col. line_err holds the number of bits in which the read data differs from the pattern, and it saturates at 2^LEW-1 (15) instead of wrapping. line_ctrl is 1 only for the control read of the activation test.
- R8: res_err is the full count, without saturation, of differing bits in the reads that can be affected. In the activation test this is line 0 only. In the precharge test it is the sum over all lines read.
- R9: busy is 1 while a sweep runs. done becomes 1 in the same cycle as the last res_valid and stays 1, with busy 0, until the next start.
- R10: A start pulse during a sweep is ignored, so the sweep keeps its sequence of delays and its number of steps.
- R11: The pattern, mode, floor, bank and rows are captured at start. A change of the pattern input during a sweep affects neither the written data nor the error counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a sweep when idle |
| test_pre | input | 1 | 0 sweeps the activation delay, 1 sweeps the precharge delay |
| floor_dly | input | DLY_W | Smallest delay in cycles to test |
| pattern | input | DW | Data written and expected in every line |
| bank | input | BW | Bank under test |
| row | input | RW | Target row |
| alt_row | input | RW | Row opened and closed before the precharge test |
| rd_valid | input | 1 | Read data present from the memory |
| rd_data | input | DW | Returned line data |
| cmd_op | output | 3 | Command code |
| cmd_bank | output | BW | Command bank |
| cmd_row | output | RW | Command row |
| cmd_col | output | CW | Command cache-line index |
| cmd_wdata | output | DW | Write data |
| line_valid | output | 1 | One line result present |
| line_col | output | CW | Line the result belongs to |
| line_ctrl | output | 1 | Result is the fully timed control read |
| line_err | output | LEW | Saturating bit-error count of the line |
| res_valid | output | 1 | Step result present |
| res_dly | output | DLY_W | Delay in cycles used by the step |
| res_err | output | SEW | Bit-error count of the step |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | Last sweep finished |

## Verification
The sweeps use all-ones, all-zeros, alternating-bit and half-word patterns. The memory model clears bits in a window that depends on how far the delay is shortened. All-ones shows the full number of flips and drives line_err into saturation. All-zeros must give zero errors at every step, which separates a correct XOR against the pattern from a plain count of ones. The alternating and half-word patterns show whether the window is counted at the right bit positions. Because the model writes damaged data back to the row, a step that skipped the rewrite would report a different count than expected.

// File: rtl/dts_pkg.sv
package dts_pkg;

    typedef enum logic [2:0] {
        OP_NOP = 3'd0,
        OP_ACT = 3'd1,
        OP_RD  = 3'd2,
        OP_WR  = 3'd3,
        OP_PRE = 3'd4
    } op_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_PACT,
        S_PWR,
        S_PPRE,
        S_XACT,
        S_XPRE,
        S_TACT,
        S_TRD,
        S_TWAIT,
        S_EPRE,
        S_STEP,
        S_GAP
    } st_e;

    // limit the requested floor to the legal range 1..hi
    function automatic int unsigned clamp_floor(input int unsigned f, input int unsigned hi);
        if (f == 0) return 1;
        if (f > hi) return hi;
        return f;
    endfunction

endpackage

// File: rtl/dts_err_count.sv
module dts_err_count #(
    parameter int DW   = 32,
    parameter int LEW  = 4,
    parameter int CNTW = $clog2(DW + 1)
) (
    input  logic [DW-1:0]   data,
    input  logic [DW-1:0]   expect_pat,
    output logic [CNTW-1:0] raw,
    output logic [LEW-1:0]  sat
);
    logic [DW-1:0] diff;

    assign diff = data ^ expect_pat;

    always_comb begin
        raw = '0;
        for (int i = 0; i < DW; i++) begin
            raw = raw + CNTW'(diff[i]);
        end
    end

    generate
        if (LEW >= CNTW) begin : g_wide
            assign sat = LEW'(raw);
        end else begin : g_narrow
            localparam int MAXV = (1 << LEW) - 1;
            assign sat = (int'(raw) > MAXV) ? '1 : LEW'(raw);
        end
    endgenerate

endmodule

// File: rtl/dts_accum.sv
module dts_accum #(
    parameter int CW    = 7,
    parameter int LEW   = 4,
    parameter int CNTW  = 6,
    parameter int SEW   = 8,
    parameter int DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line_fire,
    input  logic [CW-1:0]    col_i,
    input  logic             ctrl_i,
    input  logic             count_i,
    input  logic [CNTW-1:0]  raw_i,
    input  logic [LEW-1:0]   sat_i,
    input  logic             step_end,
    input  logic [DLY_W-1:0] dly_i,
    output logic             line_valid,
    output logic [CW-1:0]    line_col,
    output logic             line_ctrl,
    output logic [LEW-1:0]   line_err,
    output logic             res_valid,
    output logic [DLY_W-1:0] res_dly,
    output logic [SEW-1:0]   res_err
);
    logic [SEW-1:0] sum;

    always_ff @(posedge clk) begin
        if (rst) begin
            line_valid <= 1'b0;
            line_col   <= '0;
            line_ctrl  <= 1'b0;
            line_err   <= '0;
            res_valid  <= 1'b0;
            res_dly    <= '0;
            res_err    <= '0;
            sum        <= '0;
        end else begin
            line_valid <= line_fire;
            res_valid  <= step_end;
            if (line_fire) begin
                line_col  <= col_i;
                line_ctrl <= ctrl_i;
                line_err  <= sat_i;
                if (count_i) sum <= sum + SEW'(raw_i);
            end
            if (step_end) begin
                res_dly <= dly_i;
                res_err <= sum;
                sum     <= '0;
            end
        end
    end

endmodule

// File: rtl/dts_fsm.sv
module dts_fsm
    import dts_pkg::*;
#(
    parameter int STD_DLY = 6,
    parameter int DLY_W   = 4,
    parameter int NPRE    = 4,
    parameter int DW      = 32,
    parameter int BW      = 3,
    parameter int RW      = 14,
    parameter int CW      = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             test_pre,
    input  logic [DLY_W-1:0] floor_dly,
    input  logic [DW-1:0]    pattern,
    input  logic [BW-1:0]    bank,
    input  logic [RW-1:0]    row,
    input  logic [RW-1:0]    alt_row,
    input  logic             rd_valid,
    output op_e              cmd_op,
    output logic [BW-1:0]    cmd_bank,
    output logic [RW-1:0]    cmd_row,
    output logic [CW-1:0]    cmd_col,
    output logic [DW-1:0]    cmd_wdata,
    output logic [DW-1:0]    pat_q,
    output logic             line_fire,
    output logic [CW-1:0]    line_col,
    output logic             line_ctrl,
    output logic             line_cnt,
    output logic             step_end,
    output logic [DLY_W-1:0] dly_q,
    output logic             busy,
    output logic             done
);
    localparam logic [DLY_W-1:0] STD_W   = DLY_W'(STD_DLY);
    localparam logic [CW-1:0]    LAST_AC = CW'(1);
    localparam logic [CW-1:0]    LAST_PR = CW'(NPRE - 1);

    st_e              st, ret, tgt;
    logic [DLY_W-1:0] gap, flr_q, w;
    logic [CW-1:0]    col, last_col;
    logic             pre_q, adv, inc, col_clr;
    logic [BW-1:0]    bank_q;
    logic [RW-1:0]    row_q, alt_q;

    assign last_col  = pre_q ? LAST_PR : LAST_AC;
    assign busy      = (st != S_IDLE);
    assign line_col  = col;
    assign line_ctrl = !pre_q && (col == LAST_AC);
    assign line_cnt  = pre_q || (col == '0);

    always_comb begin
        cmd_op    = OP_NOP;
        cmd_bank  = bank_q;
        cmd_row   = row_q;
        cmd_col   = '0;
        cmd_wdata = '0;
        adv       = 1'b0;
        w         = DLY_W'(1);
        tgt       = st;
        inc       = 1'b0;
        col_clr   = 1'b0;
        line_fire = 1'b0;
        step_end  = 1'b0;
        case (st)
            S_PACT: begin
                cmd_op  = OP_ACT;
                adv     = 1'b1;
                w       = STD_W;
                tgt     = S_PWR;
                col_clr = 1'b1;
            end
            S_PWR: begin
                cmd_op    = OP_WR;
                cmd_col   = col;
                cmd_wdata = pat_q;
                adv       = 1'b1;
                if (col == last_col) begin
                    w   = STD_W;
                    tgt = S_PPRE;
                end else begin
                    inc = 1'b1;
                    tgt = S_PWR;
                end
            end
            S_PPRE: begin
                cmd_op = OP_PRE;
                adv    = 1'b1;
                w      = STD_W;
                tgt    = pre_q ? S_XACT : S_TACT;
            end
            S_XACT: begin
                cmd_op  = OP_ACT;
                cmd_row = alt_q;
                adv     = 1'b1;
                w       = STD_W;
                tgt     = S_XPRE;
            end
            S_XPRE: begin
                cmd_op = OP_PRE;
                adv    = 1'b1;
                w      = dly_q;
                tgt    = S_TACT;
            end
            S_TACT: begin
                cmd_op  = OP_ACT;
                adv     = 1'b1;
                col_clr = 1'b1;
                w       = pre_q ? STD_W : dly_q;
                tgt     = S_TRD;
            end
            S_TRD: begin
                cmd_op  = OP_RD;
                cmd_col = col;
                adv     = 1'b1;
                tgt     = S_TWAIT;
            end
            S_TWAIT: begin
                if (rd_valid) begin
                    line_fire = 1'b1;
                    adv       = 1'b1;
                    if (col == last_col) begin
                        tgt = S_EPRE;
                    end else begin
                        inc = 1'b1;
                        w   = pre_q ? DLY_W'(1) : STD_W;
                        tgt = S_TRD;
                    end
                end
            end
            S_EPRE: begin
                cmd_op = OP_PRE;
                adv    = 1'b1;
                w      = STD_W;
                tgt    = S_STEP;
            end
            S_STEP: step_end = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= S_IDLE;
            ret    <= S_IDLE;
            gap    <= '0;
            dly_q  <= '0;
            flr_q  <= '0;
            col    <= '0;
            pre_q  <= 1'b0;
            done   <= 1'b0;
            pat_q  <= '0;
            bank_q <= '0;
            row_q  <= '0;
            alt_q  <= '0;
        end else begin
            case (st)
                S_IDLE: begin
                    if (start) begin
                        pre_q  <= test_pre;
                        pat_q  <= pattern;
                        bank_q <= bank;
                        row_q  <= row;
                        alt_q  <= alt_row;
                        dly_q  <= STD_W;
                        flr_q  <= DLY_W'(clamp_floor(int'(floor_dly), STD_DLY));
                        done   <= 1'b0;
                        col    <= '0;
                        st     <= S_PACT;
                    end
                end
                S_GAP: begin
                    if (gap <= DLY_W'(1)) st <= ret;
                    else gap <= gap - DLY_W'(1);
                end
                S_STEP: begin
                    if (dly_q <= flr_q) begin
                        st   <= S_IDLE;
                        done <= 1'b1;
                    end else begin
                        dly_q <= dly_q - DLY_W'(1);
                        st    <= S_PACT;
                    end
                end
                default: begin
                    if (adv) begin
                        if (w <= DLY_W'(1)) begin
                            st <= tgt;
                        end else begin
                            st  <= S_GAP;
                            gap <= w - DLY_W'(1);
                            ret <= tgt;
                        end
                    end
                    if (col_clr) col <= '0;
                    else if (inc) col <= col + CW'(1);
                end
            endcase
        end
    end

endmodule

// File: rtl/dram_sweep_seq.sv
module dram_sweep_seq
    import dts_pkg::*;
#(
    parameter int  STD_DLY    = 6,
    parameter int  DLY_W      = 4,
    parameter int  DW         = 32,
    parameter int  NPRE       = 4,
    parameter int  ROW_BYTES  = 8192,
    parameter int  LINE_BYTES = 64,
    parameter int  BW         = 3,
    parameter int  RW         = 14,
    parameter int  LEW        = 4,
    localparam int LINES      = ROW_BYTES / LINE_BYTES,
    localparam int CW         = $clog2(LINES),
    localparam int SEW        = $clog2(DW * NPRE + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             test_pre,
    input  logic [DLY_W-1:0] floor_dly,
    input  logic [DW-1:0]    pattern,
    input  logic [BW-1:0]    bank,
    input  logic [RW-1:0]    row,
    input  logic [RW-1:0]    alt_row,
    input  logic             rd_valid,
    input  logic [DW-1:0]    rd_data,
    output logic [2:0]       cmd_op,
    output logic [BW-1:0]    cmd_bank,
    output logic [RW-1:0]    cmd_row,
    output logic [CW-1:0]    cmd_col,
    output logic [DW-1:0]    cmd_wdata,
    output logic             line_valid,
    output logic [CW-1:0]    line_col,
    output logic             line_ctrl,
    output logic [LEW-1:0]   line_err,
    output logic             res_valid,
    output logic [DLY_W-1:0] res_dly,
    output logic [SEW-1:0]   res_err,
    output logic             busy,
    output logic             done
);
    localparam int CNTW = $clog2(DW + 1);

    op_e              op_w;
    logic [DW-1:0]    pat_w;
    logic             fire_w, ctrl_w, cnt_w, step_w;
    logic [CW-1:0]    col_w;
    logic [DLY_W-1:0] dly_w;
    logic [CNTW-1:0]  raw_w;
    logic [LEW-1:0]   sat_w;

    assign cmd_op = op_w;

    dts_fsm #(
        .STD_DLY(STD_DLY), .DLY_W(DLY_W), .NPRE(NPRE), .DW(DW),
        .BW(BW), .RW(RW), .CW(CW)
    ) u_fsm (
        .clk(clk), .rst(rst), .start(start), .test_pre(test_pre),
        .floor_dly(floor_dly), .pattern(pattern), .bank(bank), .row(row),
        .alt_row(alt_row), .rd_valid(rd_valid),
        .cmd_op(op_w), .cmd_bank(cmd_bank), .cmd_row(cmd_row),
        .cmd_col(cmd_col), .cmd_wdata(cmd_wdata), .pat_q(pat_w),
        .line_fire(fire_w), .line_col(col_w), .line_ctrl(ctrl_w),
        .line_cnt(cnt_w), .step_end(step_w), .dly_q(dly_w),
        .busy(busy), .done(done)
    );

    dts_err_count #(.DW(DW), .LEW(LEW), .CNTW(CNTW)) u_cnt (
        .data(rd_data), .expect_pat(pat_w), .raw(raw_w), .sat(sat_w)
    );

    dts_accum #(
        .CW(CW), .LEW(LEW), .CNTW(CNTW), .SEW(SEW), .DLY_W(DLY_W)
    ) u_acc (
        .clk(clk), .rst(rst), .line_fire(fire_w), .col_i(col_w),
        .ctrl_i(ctrl_w), .count_i(cnt_w), .raw_i(raw_w), .sat_i(sat_w),
        .step_end(step_w), .dly_i(dly_w),
        .line_valid(line_valid), .line_col(line_col), .line_ctrl(line_ctrl),
        .line_err(line_err), .res_valid(res_valid), .res_dly(res_dly),
        .res_err(res_err)
    );

endmodule

// File: rtl/dts_checker.sv
module dts_checker #(
    parameter int STD_DLY = 6,
    parameter int DLY_W   = 4,
    parameter int CW      = 7
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic [2:0]       cmd_op,
    input logic             line_valid,
    input logic [CW-1:0]    line_col,
    input logic             line_ctrl,
    input logic             res_valid,
    input logic [DLY_W-1:0] res_dly
);
    logic             seen;
    logic [DLY_W-1:0] prev_dly;

    always_ff @(posedge clk) begin
        if (rst || (start && !busy)) begin
            seen     <= 1'b0;
            prev_dly <= '0;
        end else if (res_valid) begin
            seen     <= 1'b1;
            prev_dly <= res_dly;
        end
    end

    p_idle_nop_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> cmd_op == 3'd0);

    p_sweep_dec_r5: assert property (@(posedge clk) disable iff (rst)
        (res_valid && seen) |-> res_dly == prev_dly - DLY_W'(1));

    p_dly_range_r6: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (res_dly >= DLY_W'(1) && res_dly <= DLY_W'(STD_DLY)));

    p_ctrl_line_r7: assert property (@(posedge clk) disable iff (rst)
        (line_valid && line_ctrl) |-> line_col == CW'(1));

    p_line_busy_r7: assert property (@(posedge clk) disable iff (rst)
        line_valid |-> busy);

    p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    p_no_restart_r10: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> (busy || done));

endmodule

bind dram_sweep_seq dts_checker #(
    .STD_DLY(STD_DLY), .DLY_W(DLY_W), .CW(CW)
) u_chk (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .cmd_op(cmd_op), .line_valid(line_valid), .line_col(line_col),
    .line_ctrl(line_ctrl), .res_valid(res_valid), .res_dly(res_dly)
);

// File: tb/dram_sweep_seq_bench.sv
module dram_sweep_seq_bench;
    localparam int STD     = 6;
    localparam int NP      = 4;
    localparam int TRCD_OK = 5;
    localparam int TRP_OK  = 4;
    localparam logic [13:0] TROW = 14'h0123;
    localparam logic [13:0] AROW = 14'h0124;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        test_pre = 1'b0;
    logic [3:0]  floor_dly = '0;
    logic [31:0] pattern = '0;
    logic [2:0]  bank = 3'd2;
    logic [13:0] row = TROW;
    logic [13:0] alt_row = AROW;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic [2:0]  cmd_op;
    logic [2:0]  cmd_bank;
    logic [13:0] cmd_row;
    logic [6:0]  cmd_col;
    logic [31:0] cmd_wdata;
    logic        line_valid, line_ctrl, res_valid, busy, done;
    logic [6:0]  line_col;
    logic [3:0]  line_err, res_dly;
    logic [7:0]  res_err;

    always #4 clk = ~clk;

    dram_sweep_seq u_dram_sweep_seq (
        .clk(clk), .rst(rst), .start(start), .test_pre(test_pre),
        .floor_dly(floor_dly), .pattern(pattern), .bank(bank), .row(row),
        .alt_row(alt_row), .rd_valid(rd_valid), .rd_data(rd_data),
        .cmd_op(cmd_op), .cmd_bank(cmd_bank), .cmd_row(cmd_row),
        .cmd_col(cmd_col), .cmd_wdata(cmd_wdata), .line_valid(line_valid),
        .line_col(line_col), .line_ctrl(line_ctrl), .line_err(line_err),
        .res_valid(res_valid), .res_dly(res_dly), .res_err(res_err),
        .busy(busy), .done(done)
    );

    // memory model: short delays clear bits in a window, damage is written back
    function automatic logic [31:0] rcd_win(input int d);
        if (d >= TRCD_OK) return 32'h0;
        return (((TRCD_OK - 1 - d) % 2) == 0) ? 32'h0000FFFF : 32'hFFFF0000;
    endfunction

    function automatic logic [31:0] rp_win(input int d);
        if (d >= TRP_OK) return 32'h0;
        return 32'hF << ((TRP_OK - 1 - d) * 4);
    endfunction

    logic [31:0] mem [8];
    logic [31:0] pre_bad, cur_pat, rd1, rdq;
    logic        rv1, rv2, first_rd, wr_bad;
    int          cyc = 100, act_cyc = 0, pre_cyc = -1000;
    int          rcd_gap = -1, rp_gap = -1, wr_cnt = 0;

    assign rd_valid = rv2;
    assign rd_data  = rdq;

    always @(posedge clk) begin
        int          g;
        logic [31:0] m, dv;
        if (rst) begin
            rv1 <= 1'b0; rv2 <= 1'b0; rd1 <= '0; rdq <= '0;
            first_rd = 1'b0; pre_bad = '0; wr_cnt = 0; wr_bad = 1'b0;
        end else begin
            if (res_valid) begin
                wr_cnt = 0;
                wr_bad = 1'b0;
            end
            rv1 <= 1'b0;
            case (cmd_op)
                3'd1: begin
                    g = cyc - pre_cyc;
                    act_cyc = cyc;
                    first_rd = 1'b1;
                    if (cmd_row == TROW) begin
                        rp_gap = g;
                        pre_bad = rp_win(g);
                    end else pre_bad = '0;
                end
                3'd2: begin
                    g = cyc - act_cyc;
                    m = pre_bad;
                    if (first_rd) begin
                        rcd_gap = g;
                        m = m | rcd_win(g);
                    end
                    first_rd = 1'b0;
                    dv = mem[cmd_col[2:0]] & ~m;
                    mem[cmd_col[2:0]] = dv;
                    rv1 <= 1'b1;
                    rd1 <= dv;
                end
                3'd3: begin
                    mem[cmd_col[2:0]] = cmd_wdata;
                    wr_cnt = wr_cnt + 1;
                    if (cmd_wdata != cur_pat) wr_bad = 1'b1;
                end
                3'd4: pre_cyc = cyc;
                default: ;
            endcase
            rv2 <= rv1;
            rdq <= rd1;
            cyc = cyc + 1;
        end
    end

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic run_case(input bit pm, input int flr, input logic [31:0] pat,
                            input bit poke_start, input bit poke_pat);
        int   eff, exp_d, steps, lines, exp_col, raw, sat, cyc_n;
        logic [31:0] w;
        eff = (flr == 0) ? 1 : ((flr > STD) ? STD : flr);
        tick();
        cur_pat   = pat;
        test_pre  = pm;
        floor_dly = 4'(flr);
        pattern   = pat;
        start     = 1'b1;
        tick();
        start = 1'b0;
        exp_d = STD; steps = 0; lines = 0; exp_col = 0; cyc_n = 0;
        while (cyc_n < 5000) begin
            tick();
            cyc_n++;
            if (cyc_n == 10 && poke_start) start = 1'b1;
            if (cyc_n == 11) start = 1'b0;
            if (cyc_n == 10 && poke_pat) pattern = ~pat;
            if (line_valid) begin
                w   = pm ? rp_win(exp_d) : ((exp_col == 0) ? rcd_win(exp_d) : 32'h0);
                raw = $countones(pat & w);
                sat = (raw > 15) ? 15 : raw;
                chk(int'(line_col) == exp_col, pm ? "R4 line order" : "R3 line order",
                    int'(line_col), exp_col);
                chk(int'(line_err) == sat, "R7 line_err saturating", int'(line_err), sat);
                chk(line_ctrl == (!pm && exp_col == 1), "R7 line_ctrl",
                    int'(line_ctrl), int'(!pm && exp_col == 1));
                exp_col++;
                lines++;
            end
            if (res_valid) begin
                raw = pm ? NP * $countones(pat & rp_win(exp_d))
                         : $countones(pat & rcd_win(exp_d));
                chk(int'(res_dly) == exp_d, "R5 step delay", int'(res_dly), exp_d);
                chk(int'(res_err) == raw, "R8 step error count", int'(res_err), raw);
                chk(lines == (pm ? NP : 2), pm ? "R4 lines read" : "R3 lines read",
                    lines, pm ? NP : 2);
                if (pm) chk(rp_gap == exp_d, "R4 PRE to ACT spacing", rp_gap, exp_d);
                else    chk(rcd_gap == exp_d, "R3 ACT to RD spacing", rcd_gap, exp_d);
                chk(wr_cnt == (pm ? NP : 2) && !wr_bad, "R2 R11 row rewrite",
                    wr_cnt, pm ? NP : 2);
                chk(done == (exp_d == eff), "R9 done timing", int'(done), int'(exp_d == eff));
                steps++;
                exp_d--;
                lines = 0;
                exp_col = 0;
                if (done) break;
            end
        end
        chk(steps == STD - eff + 1, poke_start ? "R10 step count" : "R6 step count",
            steps, STD - eff + 1);
        tick();
        chk(!busy && done, "R9 idle after sweep", int'(busy), 0);
    endtask

    localparam logic [36:0] VEC [6] = '{
        {1'b0, 4'd1, 32'hFFFFFFFF},
        {1'b0, 4'd3, 32'hAAAAAAAA},
        {1'b0, 4'd2, 32'h00000000},
        {1'b1, 4'd1, 32'hFFFFFFFF},
        {1'b1, 4'd2, 32'h0000FFFF},
        {1'b0, 4'd1, 32'hFFFF0000}
    };

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        chk(!busy && !done && !line_valid && !res_valid, "R1 reset outputs",
            int'({busy, done, line_valid, res_valid}), 0);
        chk(cmd_op == 3'd0, "R1 reset NOP", int'(cmd_op), 0);
        foreach (VEC[i]) begin
            run_case(VEC[i][36], int'(VEC[i][35:32]), VEC[i][31:0], 1'b0, 1'b0);
        end
        run_case(1'b0, 0, 32'hFFFFFFFF, 1'b0, 1'b0);   // R6 floor 0 acts as 1
        run_case(1'b1, 9, 32'hFFFFFFFF, 1'b0, 1'b0);   // R6 floor above standard
        run_case(1'b0, 4, 32'hFFFFFFFF, 1'b1, 1'b0);   // R10 start while busy
        run_case(1'b1, 1, 32'h0F0F0F0F, 1'b0, 1'b1);   // R11 pattern changed mid-run
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule